// File: doc/BRIEF.md
# Scatter-Gather Segment List Walker

This block is the fetch front end of a hash engine. Software puts a list of data segments in memory and starts the block with the list's base address. The block reads each 8-byte list entry through a 32-bit memory read port. It turns each entry into a segment address and a segment length, and it offers that segment on a valid/ready output. A later stage reads and hashes the segment payload.

Each entry holds a length word first and an address word second. The top bit of the length word marks the final entry. The walk ends after that entry has been handed over. It also ends after the entry at a fixed limit. If that limit entry is not marked as final, an error is raised. In direct mode no memory is read: one segment is built from the address and length inputs. A single-cycle done pulse reports the end of every walk, together with the number of segments emitted.

Top module: `sg_walker`

## Requirements
- R1: After reset, `seg_valid_o`, `mem_req_o`, `busy_o`, `done_o` and `err_o` are low and `seg_count_o` is zero.
- R2: In list mode, entry i is read at the base address (its low 3 bits forced to zero) plus 8*i. The length word is read first. The address word is read next, at +4. The request address holds steady until `mem_valid_i` completes the read.
- R3: The segment length is bits [27:0] of the length word. Bits [30:28] of that word have no effect.
- R4: The segment address is bits [30:0] of the address word. Bit 31 of that word has no effect.
- R5: A length word with bit 31 set ends the list. Its segment is emitted with `seg_last_o` high, and no further entry is read.
- R6: The walk stops after the segment of entry number MAX_DESC (256) has been handed over, even if that entry is not marked final. That segment carries `seg_last_o`, and the walk ends with `err_o` high and a count of 256.
- R7: In direct mode (`sg_mode_i` low at start), exactly one segment is emitted from `direct_addr_i` and `direct_len_i`, with `seg_last_o` high and no memory request.
- R8: At most one segment is outstanding. No memory request is made while `seg_valid_o` is high. The segment outputs hold steady while `seg_valid_o` is high and `seg_ready_i` is low.
- R9: `seg_count_o` equals the number of segments handed over, and it is valid when `done_o` pulses. A segment of zero length is still emitted.
- R10: A start pulse that arrives while `busy_o` is high is ignored.
- R11: `done_o` is high for exactly one cycle, in the cycle after the final handshake. An accepted start clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| sg_mode_i | input | 1 | 1 = walk the list, 0 = direct single segment |
| base_addr_i | input | ADDR_W | List base address |
| direct_addr_i | input | SADDR_W | Segment address for direct mode |
| direct_len_i | input | LEN_W | Segment length for direct mode |
| mem_req_o | output | 1 | Memory read request, held until completed |
| mem_addr_o | output | ADDR_W | Byte address of the word being read |
| mem_valid_i | input | 1 | Read data valid; completes the current request |
| mem_data_i | input | 32 | Little-endian read data word |
| seg_valid_o | output | 1 | Segment offered |
| seg_ready_i | input | 1 | Segment accepted when high together with valid |
| seg_addr_o | output | SADDR_W | Segment start address |
| seg_len_o | output | LEN_W | Segment length in bytes |
| seg_last_o | output | 1 | Final segment of the walk |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 1 | Walk ended at the entry limit without a final mark |
| seg_count_o | output | CNT_W | Segments emitted by the last walk |

## Verification
A wrong entry index or a wrong word phase shows up on the very next segment as an address or length that does not match the memory model's list. A broken end test behaves in one of two ways. Either the walk runs on and reads entries past the marked one, which the bench sees as an extra segment and a late done pulse, or it ends early with a short count. A stale limit counter shows up only at the limit: the 256-entry run ends with the wrong count, the wrong error flag, or a missing final mark.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int WORD_W   = 32;
    localparam int SEG_LEN_W  = 28;
    localparam int SEG_ADDR_W = 31;
    localparam int END_BIT  = 31;
    localparam int ENTRY_BYTES = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_LEN  = 2'd1,
        ST_RD_ADDR = 2'd2,
        ST_EMIT    = 2'd3
    } walk_state_e;
endpackage

// File: rtl/sgw_word_split.sv
module sgw_word_split #(
    parameter int WORD_W  = 32,
    parameter int LEN_W   = 28,
    parameter int SADDR_W = 31,
    parameter int END_BIT = 31
) (
    input  logic [WORD_W-1:0]  word_i,
    output logic [LEN_W-1:0]   len_o,
    output logic               end_o,
    output logic [SADDR_W-1:0] addr_o
);
    // The same bus word is seen either as a length word or as an address word.
    always_comb begin
        len_o  = word_i[LEN_W-1:0];
        end_o  = word_i[END_BIT];
        addr_o = word_i[SADDR_W-1:0];
    end
endmodule

// File: rtl/sgw_index_gen.sv
module sgw_index_gen #(
    parameter int ADDR_W   = 32,
    parameter int MAX_DESC = 256,
    parameter int IDX_W    = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              hi_word_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              at_limit_o
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(7);
    localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(MAX_DESC - 1);

    logic [ADDR_W-1:0] entry_off;

    always_comb begin
        entry_off  = ADDR_W'(idx_i) << 3;
        addr_o     = (base_i & ~ALIGN_MASK) + entry_off
                   + (hi_word_i ? ADDR_W'(4) : ADDR_W'(0));
        at_limit_o = (idx_i == LAST_IDX);
    end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MAX_DESC = 256,
    parameter int LEN_W    = SEG_LEN_W,
    parameter int SADDR_W  = SEG_ADDR_W,
    parameter int CNT_W    = $clog2(MAX_DESC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               sg_mode_i,
    input  logic [ADDR_W-1:0]  base_addr_i,
    input  logic [SADDR_W-1:0] direct_addr_i,
    input  logic [LEN_W-1:0]   direct_len_i,
    output logic               mem_req_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    input  logic               mem_valid_i,
    input  logic [WORD_W-1:0]  mem_data_i,
    output logic               seg_valid_o,
    input  logic               seg_ready_i,
    output logic [SADDR_W-1:0] seg_addr_o,
    output logic [LEN_W-1:0]   seg_len_o,
    output logic               seg_last_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic [CNT_W-1:0]   seg_count_o
);
    localparam int IDX_W = (MAX_DESC > 2) ? $clog2(MAX_DESC) : 1;

    typedef struct packed {
        walk_state_e        st;
        logic [IDX_W-1:0]   idx;
        logic [ADDR_W-1:0]  base;
        logic [LEN_W-1:0]   len;
        logic [SADDR_W-1:0] saddr;
        logic               marked;
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic               err;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [LEN_W-1:0]   w_len;
    logic               w_end;
    logic [SADDR_W-1:0] w_addr;
    logic [ADDR_W-1:0]  fetch_addr;
    logic               at_limit;
    logic               final_seg;

    sgw_word_split #(
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W),
        .SADDR_W(SADDR_W),
        .END_BIT(END_BIT)
    ) u_split (
        .word_i(mem_data_i),
        .len_o (w_len),
        .end_o (w_end),
        .addr_o(w_addr)
    );

    sgw_index_gen #(
        .ADDR_W  (ADDR_W),
        .MAX_DESC(MAX_DESC),
        .IDX_W   (IDX_W)
    ) u_index (
        .base_i    (r_q.base),
        .idx_i     (r_q.idx),
        .hi_word_i (r_q.st == ST_RD_ADDR),
        .addr_o    (fetch_addr),
        .at_limit_o(at_limit)
    );

    // Direct mode keeps idx at 0, so the limit can only end a list walk.
    assign final_seg = r_q.marked | at_limit;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.cnt  = '0;
                    r_d.err  = 1'b0;
                    r_d.idx  = '0;
                    r_d.base = base_addr_i;
                    if (sg_mode_i) begin
                        r_d.st = ST_RD_LEN;
                    end else begin
                        r_d.saddr  = direct_addr_i;
                        r_d.len    = direct_len_i;
                        r_d.marked = 1'b1;
                        r_d.st     = ST_EMIT;
                    end
                end
            end
            ST_RD_LEN: begin
                if (mem_valid_i) begin
                    r_d.len    = w_len;
                    r_d.marked = w_end;
                    r_d.st     = ST_RD_ADDR;
                end
            end
            ST_RD_ADDR: begin
                if (mem_valid_i) begin
                    r_d.saddr = w_addr;
                    r_d.st    = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (seg_ready_i) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (final_seg) begin
                        r_d.done = 1'b1;
                        r_d.err  = ~r_q.marked;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_RD_LEN;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_o   = (r_q.st == ST_RD_LEN) || (r_q.st == ST_RD_ADDR);
    assign mem_addr_o  = fetch_addr;
    assign seg_valid_o = (r_q.st == ST_EMIT);
    assign seg_addr_o  = r_q.saddr;
    assign seg_len_o   = r_q.len;
    assign seg_last_o  = final_seg;
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
    assign seg_count_o = r_q.cnt;
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
    parameter int ADDR_W   = 32,
    parameter int MAX_DESC = 256,
    parameter int LEN_W    = 28,
    parameter int SADDR_W  = 31,
    parameter int CNT_W    = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req_o,
    input logic [ADDR_W-1:0]  mem_addr_o,
    input logic               mem_valid_i,
    input logic               seg_valid_o,
    input logic               seg_ready_i,
    input logic [SADDR_W-1:0] seg_addr_o,
    input logic [LEN_W-1:0]   seg_len_o,
    input logic               seg_last_o,
    input logic               done_o,
    input logic               err_o,
    input logic [CNT_W-1:0]   seg_count_o
);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_valid_i && !mem_addr_o[2])
        |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid_o |-> !mem_req_o);

    assert_seg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid_o && !seg_ready_i)
        |=> (seg_valid_o && $stable({seg_addr_o, seg_len_o, seg_last_o})));

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid_o && seg_ready_i && seg_last_o) |=> done_o);

    assert_limit_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (seg_count_o == CNT_W'(MAX_DESC)));

    assert_count_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (seg_count_o != '0 && seg_count_o <= CNT_W'(MAX_DESC)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind sg_walker sgw_checker #(
    .ADDR_W  (ADDR_W),
    .MAX_DESC(MAX_DESC),
    .LEN_W   (LEN_W),
    .SADDR_W (SADDR_W),
    .CNT_W   (CNT_W)
) u_chk (.*);

// File: tb/sim_sg_walker.sv
module sim_sg_walker;
    localparam int ADDR_W = 32;
    localparam int MAXD   = 256;
    localparam int LEN_W  = 28;
    localparam int SAW    = 31;
    localparam int CNT_W  = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic sg_mode_i = 1'b0;
    logic [ADDR_W-1:0] base_addr_i = '0;
    logic [SAW-1:0] direct_addr_i = '0;
    logic [LEN_W-1:0] direct_len_i = '0;
    logic mem_req_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic mem_valid_i = 1'b0;
    logic [31:0] mem_data_i = '0;
    logic seg_valid_o;
    logic seg_ready_i = 1'b0;
    logic [SAW-1:0] seg_addr_o;
    logic [LEN_W-1:0] seg_len_o;
    logic seg_last_o, busy_o, done_o, err_o;
    logic [CNT_W-1:0] seg_count_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [1024];

    always #2 clk = ~clk;

    sg_walker #(.ADDR_W(ADDR_W), .MAX_DESC(MAXD)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sg_mode_i(sg_mode_i),
        .base_addr_i(base_addr_i), .direct_addr_i(direct_addr_i),
        .direct_len_i(direct_len_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i),
        .seg_valid_o(seg_valid_o), .seg_ready_i(seg_ready_i),
        .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o), .seg_last_o(seg_last_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .seg_count_o(seg_count_o)
    );

    // Memory model: answers one cycle after a request is seen.
    always @(posedge clk) begin
        mem_valid_i <= mem_req_o && !mem_valid_i;
        mem_data_i  <= mem[mem_addr_o[11:2]];
    end

    function automatic logic [LEN_W-1:0] exp_len(int k, int bw);
        return (k == 2) ? '0 : LEN_W'(k * 4099 + bw * 3 + 1);
    endfunction

    function automatic logic [SAW-1:0] exp_addr(int k, int bw);
        return SAW'(k * 32'h0123457 + bw * 16 + 32'h4000_0000);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bits 30:28 of length words and bit 31 of address words carry noise.
    task automatic fill(input int bw, input int n, input bit terminate);
        for (int k = 0; k < n; k++) begin
            mem[bw + 2*k]     = {(terminate && k == n-1), 3'b101, exp_len(k, bw)};
            mem[bw + 2*k + 1] = {1'b1, exp_addr(k, bw)};
        end
    endtask

    task automatic run_walk(input bit sg, input int bw, input int boff, input int n,
                            input logic [3:0] rdy, input bit exp_err, input bit glitch);
        int k = 0;
        int cyc = 0;
        bit fin = 1'b0;
        @(negedge clk);
        sg_mode_i = sg;
        base_addr_i = ADDR_W'(bw * 4 + boff);
        direct_addr_i = 31'h5A5A_1234;
        direct_len_i = 28'h0ABCDEF;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!err_o && busy_o, "R11 err cleared, busy on start", {err_o, busy_o}, 2'b01);
        while (!fin && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (glitch && cyc == 3) begin
                start_i = 1'b1; sg_mode_i = ~sg; base_addr_i = 32'h0000_0F00;
            end else begin
                start_i = 1'b0;
            end
            seg_ready_i = rdy[cyc % 4];
            if (mem_req_o && !sg)
                check(1'b0, "R7 memory request in direct mode", mem_addr_o, 0);
            if (done_o) begin
                fin = 1'b1;
                check(k == n, "R9 segments seen", k, n);
                check(seg_count_o == CNT_W'(n), "R9 seg_count", seg_count_o, n);
                check(err_o == exp_err, "R6 err flag", err_o, exp_err);
            end else if (seg_valid_o && seg_ready_i) begin
                if (sg) begin
                    check(seg_addr_o == exp_addr(k, bw), "R2 R4 seg addr", seg_addr_o, exp_addr(k, bw));
                    check(seg_len_o == exp_len(k, bw), "R3 seg len", seg_len_o, exp_len(k, bw));
                end else begin
                    check(seg_addr_o == 31'h5A5A_1234, "R7 direct addr", seg_addr_o, 31'h5A5A_1234);
                    check(seg_len_o == 28'h0ABCDEF, "R7 direct len", seg_len_o, 28'h0ABCDEF);
                end
                check(seg_last_o == (k == n-1), "R5 seg_last", seg_last_o, k == n-1);
                k++;
            end
        end
        check(fin, "R5 walk finished", fin, 1);
        start_i = 1'b0;
        seg_ready_i = 1'b0;
        @(negedge clk);
        check(!done_o && !busy_o && !mem_req_o, "R11 done single pulse",
              {done_o, busy_o, mem_req_o}, 0);
    endtask

    typedef struct packed {
        logic       sg;
        logic [9:0] bw;
        logic [2:0] boff;
        logic [8:0] n;
        logic [3:0] rdy;
    } vec_t;

    // R2: entry 4 uses an unaligned base whose low bits must be dropped.
    localparam vec_t VECS [6] = '{
        '{1'b1, 10'h000, 3'd0, 9'd1, 4'hF},
        '{1'b1, 10'h040, 3'd0, 9'd3, 4'b0101},
        '{1'b1, 10'h080, 3'd0, 9'd5, 4'b1101},
        '{1'b0, 10'h000, 3'd0, 9'd1, 4'b0110},
        '{1'b1, 10'h100, 3'd5, 9'd2, 4'hF},
        '{1'b1, 10'h140, 3'd0, 9'd4, 4'b0011}
    };

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(!seg_valid_o && !mem_req_o && !busy_o && !done_o && !err_o && seg_count_o == 0,
              "R1 reset state", {seg_valid_o, mem_req_o, busy_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        for (int v = 0; v < 6; v++) begin
            if (VECS[v].sg) fill(int'(VECS[v].bw), int'(VECS[v].n), 1'b1);
            run_walk(VECS[v].sg, int'(VECS[v].bw), int'(VECS[v].boff), int'(VECS[v].n),
                     VECS[v].rdy, 1'b0, 1'b0);
        end
        // R10: a start during a walk with other mode and base is ignored.
        fill(16'h1C0, 3, 1'b1);
        run_walk(1'b1, 'h1C0, 0, 3, 4'b1001, 1'b0, 1'b1);
        // R6: 256 entries, none marked final.
        fill('h200, MAXD, 1'b0);
        run_walk(1'b1, 'h200, 0, MAXD, 4'hF, 1'b1, 1'b0);
        // R11: err cleared by the next accepted start (checked in run_walk).
        run_walk(1'b0, 0, 0, 1, 4'hF, 1'b0, 1'b0);
        // R9: zero-length third entry in a short list.
        fill('h180, 3, 1'b1);
        run_walk(1'b1, 'h180, 0, 3, 4'b1010, 1'b0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule